// File: doc/BRIEF.md
# ADC Gain and Offset Correction Unit

This unit sits directly after a 12-bit converter engine. It takes each raw conversion result and returns a 14-bit corrected code. When correction is requested, the unit scales the raw code by an unsigned gain coefficient, adds a signed offset coefficient, and then adds a fixed half-step term. All of this arithmetic runs at four times the raw resolution, which gives quarter-step output granularity. Spreading the stretched staircase over that finer grid keeps the unit from skipping output codes.

Each raw result arrives with a valid strobe and a per-conversion flag that asks for correction. If the flag is low, the raw code is still shifted up by two bits and given the same half-step term. Downstream logic therefore always sees one 14-bit format. The two coefficients sit in a small register pair that is loaded through a register-write port. Every conversion takes a snapshot of the coefficients at the moment it is sampled and uses that snapshot for its whole trip through the three-stage pipeline.

Top module: `adc_lin_corrector`

## Requirements
- R1: While `rst_n` is low, `res_valid` and `res_code` are 0. After reset the gain is 0x4000 (unity) and the offset is 0, so a corrected conversion of raw value x yields 4x+2.
- R2: A result is presented on `res_valid` exactly three cycles after `raw_valid` is sampled high. The unit accepts one conversion per cycle with no gaps.
- R3: With `raw_cal`=1 the result is floor(gain*(raw*4)/16384) + offset + 2. Here gain is an unsigned value with 1 integer bit and 14 fraction bits, and offset is 14-bit two's complement.
- R4: With `raw_cal`=0 the result is raw*4+2 whatever the coefficient values are.
- R5: A write to address 0x04 loads the gain from `cfg_wdata[14:0]`. Bit 15 of the write data has no effect.
- R6: A write to address 0x05 loads the offset from `cfg_wdata[13:0]`. Bits 15:14 of the write data have no effect.
- R7: A write to any other address changes neither coefficient.
- R8: A corrected sum below 0 is output as 0, and a sum above 16383 is output as 16383. The output never wraps.
- R9: A conversion uses the coefficients held at the edge where it is sampled. A write on that same edge, or on any later edge, does not alter that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 8 | Coefficient register address |
| cfg_wdata | input | 16 | Coefficient write data |
| raw_valid | input | 1 | Raw result strobe |
| raw_code | input | 12 | Raw converter result |
| raw_cal | input | 1 | Request correction for this result |
| res_valid | output | 1 | Corrected result strobe |
| res_code | output | 14 | Corrected 14-bit result |

## Verification
The bench targets four corner cases:

- **Both clamp limits.** It drives maximum gain with maximum positive offset, and zero input with the most negative offset. A design that wraps would return a small code at the top or a code near full scale at the bottom.
- **Reserved write-data bits.** It sets the reserved bits on both coefficient writes. A design with a mis-sliced field would load a gain near zero or flip the sign of the offset.
- **Write coinciding with a conversion.** It issues a coefficient write on the same edge as a conversion, and a burst of writes while conversions are in flight. A design without a per-conversion snapshot would correct those results with the new values.
- **Uncorrected path with non-unity coefficients.** It runs uncorrected conversions after loading non-unity coefficients, which would expose a bypass that leaks gain or offset into that path.

// File: rtl/adc_corr_pkg.sv
// Package: shared widths and constants of the gain/offset correction unit.
// Assumes: output is RAW_W + 2 bits wide (quarter-step resolution).
package adc_corr_pkg;
    localparam int RAW_W     = 12;
    localparam int GAIN_W    = 15;
    localparam int FRAC_W    = 14;
    localparam int OFF_W     = 14;
    localparam int OUT_W     = 14;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 16;
    localparam int GAIN_ADDR = 4;
    localparam int OFF_ADDR  = 5;
endpackage

// File: rtl/corr_coef_regs.sv
// Module: holds the gain and offset coefficients and loads them from the
// register-write port. Assumes write data is right-aligned: the gain takes
// the low GAIN_W bits and the offset the low OFF_W bits; higher bits are dropped.
module corr_coef_regs #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int GAIN_W    = 15,
    parameter int FRAC_W    = 14,
    parameter int OFF_W     = 14,
    parameter int GAIN_ADDR = 4,
    parameter int OFF_ADDR  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [GAIN_W-1:0] gain,
    output logic [OFF_W-1:0]  offset
);
    localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1) << FRAC_W;

    logic hit_gain;
    logic hit_off;

    // Decode which coefficient, if any, this write targets.
    always_comb begin
        hit_gain = we && (addr == ADDR_W'(GAIN_ADDR));
        hit_off  = we && (addr == ADDR_W'(OFF_ADDR));
    end

    // Coefficient storage with unity gain / zero offset after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain   <= GAIN_UNITY;
            offset <= '0;
        end else begin
            if (hit_gain) gain   <= wdata[GAIN_W-1:0];
            if (hit_off)  offset <= wdata[OFF_W-1:0];
        end
    end

    // R7
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr != ADDR_W'(GAIN_ADDR) && addr != ADDR_W'(OFF_ADDR))
        |=> ($stable(gain) && $stable(offset)));
endmodule

// File: rtl/corr_scale_stage.sv
// Module: first two pipeline stages. Stage 1 captures the raw code, the flag
// and a snapshot of the coefficients; stage 2 forms gain*(raw<<SHIFT)>>FRAC_W.
// Assumes one conversion per cycle at most; the pipeline never stalls.
module corr_scale_stage #(
    parameter int RAW_W  = 12,
    parameter int GAIN_W = 15,
    parameter int FRAC_W = 14,
    parameter int OFF_W  = 14,
    parameter int OUT_W  = 14,
    localparam int SHIFT  = OUT_W - RAW_W,
    localparam int PROD_W = GAIN_W + RAW_W + SHIFT,
    localparam int SCL_W  = PROD_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [RAW_W-1:0]  in_raw,
    input  logic              in_cal,
    input  logic [GAIN_W-1:0] cur_gain,
    input  logic [OFF_W-1:0]  cur_off,
    output logic              s2_valid,
    output logic              s2_cal,
    output logic [RAW_W-1:0]  s2_raw,
    output logic [OFF_W-1:0]  s2_off,
    output logic [SCL_W-1:0]  s2_scaled
);
    logic              s1_valid;
    logic              s1_cal;
    logic [RAW_W-1:0]  s1_raw;
    logic [GAIN_W-1:0] s1_gain;
    logic [OFF_W-1:0]  s1_off;
    logic [PROD_W-1:0] prod;

    // Stage 1: capture the conversion and freeze its coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_cal   <= 1'b0;
            s1_raw   <= '0;
            s1_gain  <= '0;
            s1_off   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_cal  <= in_cal;
                s1_raw  <= in_raw;
                s1_gain <= cur_gain;
                s1_off  <= cur_off;
            end
        end
    end

    // Full-width product of gain and the raw code at quarter-step scale.
    always_comb begin
        prod = PROD_W'(s1_gain) * PROD_W'({s1_raw, {SHIFT{1'b0}}});
    end

    // Stage 2: keep the integer part of the product and carry the rest along.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_cal    <= 1'b0;
            s2_raw    <= '0;
            s2_off    <= '0;
            s2_scaled <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_cal    <= s1_cal;
                s2_raw    <= s1_raw;
                s2_off    <= s1_off;
                s2_scaled <= prod[PROD_W-1:FRAC_W];
            end
        end
    end

    // R9
    snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(s1_gain) && $stable(s1_off)));
endmodule

// File: rtl/corr_sum_stage.sv
// Module: output stage. Adds the signed offset and the half-step term to the
// scaled value and clamps the sum into the output range; in bypass it emits
// raw<<SHIFT plus the half-step term. Assumes OUT_W > RAW_W.
module corr_sum_stage #(
    parameter int RAW_W = 12,
    parameter int OFF_W = 14,
    parameter int OUT_W = 14,
    parameter int SCL_W = 15,
    localparam int SHIFT = OUT_W - RAW_W,
    localparam int SUM_W = SCL_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s2_valid,
    input  logic             s2_cal,
    input  logic [RAW_W-1:0] s2_raw,
    input  logic [OFF_W-1:0] s2_off,
    input  logic [SCL_W-1:0] s2_scaled,
    output logic             res_valid,
    output logic [OUT_W-1:0] res_code
);
    localparam logic signed [SUM_W-1:0] HALF    = SUM_W'(1) << (SHIFT - 1);
    localparam logic signed [SUM_W-1:0] TOP_VAL = SUM_W'((1 << OUT_W) - 1);

    logic signed [SUM_W-1:0] sum;
    logic [OUT_W-1:0]        cal_code;
    logic [OUT_W-1:0]        bypass_code;

    // Signed sum of scaled value, sign-extended offset and half-step term.
    always_comb begin
        sum = $signed({2'b00, s2_scaled})
            + $signed({{(SUM_W-OFF_W){s2_off[OFF_W-1]}}, s2_off})
            + HALF;
    end

    // Clamp the corrected sum to the unsigned output range.
    always_comb begin
        if (sum < 0)             cal_code = '0;
        else if (sum > TOP_VAL)  cal_code = '1;
        else                     cal_code = sum[OUT_W-1:0];
    end

    // Bypass format: raw code moved to quarter-step scale plus half step.
    always_comb begin
        bypass_code = {s2_raw, {SHIFT{1'b0}}} | OUT_W'(HALF);
    end

    // Output register selecting corrected or bypass code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= '0;
        end else begin
            res_valid <= s2_valid;
            if (s2_valid) res_code <= s2_cal ? cal_code : bypass_code;
        end
    end

    // R4
    bypass_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && !s2_cal) |=> (res_code[SHIFT-1:0] == SHIFT'(HALF)));
endmodule

// File: rtl/adc_lin_corrector.sv
// Module: top of the gain/offset correction unit. Wires the coefficient
// registers to a three-stage pipeline (capture, scale, sum/clamp).
// Assumes raw_valid is held low by the source while rst_n is low.
module adc_lin_corrector
    import adc_corr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              raw_valid,
    input  logic [RAW_W-1:0]  raw_code,
    input  logic              raw_cal,
    output logic              res_valid,
    output logic [OUT_W-1:0]  res_code
);
    localparam int SCL_W = GAIN_W + OUT_W - FRAC_W;

    logic [GAIN_W-1:0] gain;
    logic [OFF_W-1:0]  offset;
    logic              s2_valid;
    logic              s2_cal;
    logic [RAW_W-1:0]  s2_raw;
    logic [OFF_W-1:0]  s2_off;
    logic [SCL_W-1:0]  s2_scaled;
    logic [1:0]        warm;

    corr_coef_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W),
        .OFF_W(OFF_W), .GAIN_ADDR(GAIN_ADDR), .OFF_ADDR(OFF_ADDR)
    ) u_coef (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .gain(gain), .offset(offset)
    );

    corr_scale_stage #(
        .RAW_W(RAW_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .OFF_W(OFF_W), .OUT_W(OUT_W)
    ) u_scale (
        .clk(clk), .rst_n(rst_n), .in_valid(raw_valid), .in_raw(raw_code),
        .in_cal(raw_cal), .cur_gain(gain), .cur_off(offset),
        .s2_valid(s2_valid), .s2_cal(s2_cal), .s2_raw(s2_raw),
        .s2_off(s2_off), .s2_scaled(s2_scaled)
    );

    corr_sum_stage #(
        .RAW_W(RAW_W), .OFF_W(OFF_W), .OUT_W(OUT_W), .SCL_W(SCL_W)
    ) u_sum (
        .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_cal(s2_cal),
        .s2_raw(s2_raw), .s2_off(s2_off), .s2_scaled(s2_scaled),
        .res_valid(res_valid), .res_code(res_code)
    );

    // Counts edges since reset release so latency checks never look before reset.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm <= 2'd0;
        else if (warm != 2'd3)   warm <= warm + 2'd1;
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (res_valid == $past(raw_valid, 3)));

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!res_valid && res_code == '0));
endmodule

// File: tb/adc_lin_corrector_bench.sv
module adc_lin_corrector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        raw_valid = 1'b0;
    logic [11:0] raw_code = '0;
    logic        raw_cal = 1'b0;
    logic        res_valid;
    logic [13:0] res_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural model state
    int  m_gain = 16384;
    int  m_off  = 0;
    bit  ev[3];
    int  ec[3];
    string et[3];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_lin_corrector u_adc_lin_corrector (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .raw_valid(raw_valid), .raw_code(raw_code),
        .raw_cal(raw_cal), .res_valid(res_valid), .res_code(res_code)
    );

    function automatic int ref_code(int raw, bit cal, int g, int o);
        longint s;
        if (!cal) return raw * 4 + 2;
        s = ((longint'(g) * longint'(raw * 4)) >>> 14) + o + 2;
        if (s < 0) s = 0;
        if (s > 16383) s = 16383;
        return int'(s);
    endfunction

    task automatic compare_now();
        checks++;
        if (res_valid !== ev[2] || (ev[2] && res_code !== 14'(ec[2]))) begin
            fails++;
            $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
                     et[2], res_valid, res_code, ev[2], ec[2]);
        end
    endtask

    // One clock: drive at negedge, model the edge, compare at next negedge.
    task automatic cyc(bit v, int raw, bit cal, bit we, int addr, int data, string t);
        raw_valid = v; raw_code = 12'(raw); raw_cal = cal;
        cfg_we = we; cfg_addr = 8'(addr); cfg_wdata = 16'(data);
        @(posedge clk);
        ev[2] = ev[1]; ec[2] = ec[1]; et[2] = et[1];
        ev[1] = ev[0]; ec[1] = ec[0]; et[1] = et[0];
        ev[0] = v; ec[0] = ref_code(raw, cal, m_gain, m_off); et[0] = t;
        if (we && addr == 4) m_gain = data & 32'h7FFF;
        if (we && addr == 5) m_off = ((data & 32'h3FFF) >= 8192) ? (data & 32'h3FFF) - 16384
                                                                 : (data & 32'h3FFF);
        @(negedge clk);
        compare_now();
    endtask

    task automatic conv(int raw, bit cal, string t);
        cyc(1'b1, raw, cal, 1'b0, 0, 0, t);
    endtask

    task automatic wr(int addr, int data, string t);
        cyc(1'b0, 0, 1'b0, 1'b1, addr, data, t);
    endtask

    task automatic drain(string t);
        for (int i = 0; i < 3; i++) cyc(1'b0, 0, 1'b0, 1'b0, 0, 0, t);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin ev[i] = 1'b0; ec[i] = 0; et[i] = "R2"; end
        @(negedge clk);
        // R1: outputs idle and zero while reset is held
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (res_valid !== 1'b0 || res_code !== 14'd0) begin
                fails++;
                $display("FAIL R1: valid=%0b code=%0d expected valid=0 code=0", res_valid, res_code);
            end
        end
        rst_n = 1'b1;
        // R1: unity gain and zero offset after reset
        conv(0, 1'b1, "R1"); conv(100, 1'b1, "R1"); conv(4095, 1'b1, "R1");
        drain("R2");
        // R5: gain about 0.98 at address 0x04
        wr(4, 16'h3F00, "R5");
        conv(2048, 1'b1, "R5"); conv(1234, 1'b1, "R3");
        // R6: offset -40 with reserved upper bits set
        wr(5, 16'hFFD8, "R6");
        conv(1000, 1'b1, "R6"); conv(3, 1'b1, "R3");
        // R5: reserved gain bit 15 set, gain 0x4200
        wr(4, 16'hC200, "R5");
        conv(4000, 1'b1, "R5"); conv(777, 1'b1, "R3");
        // R7: foreign addresses leave coefficients intact
        wr(6, 16'h0123, "R7"); wr(3, 16'h7FFF, "R7"); wr(8'h84, 16'h0000, "R7");
        conv(2500, 1'b1, "R7");
        // R4: bypass ignores non-unity coefficients
        conv(0, 1'b0, "R4"); conv(4095, 1'b0, "R4"); conv(1500, 1'b0, "R4");
        drain("R2");
        // R8: upper clamp with maximum gain and offset
        wr(4, 16'h7FFF, "R8"); wr(5, 16'h1FFF, "R8");
        conv(4095, 1'b1, "R8"); conv(2000, 1'b1, "R8");
        // R8: lower clamp with most negative offset
        wr(4, 16'h4000, "R8"); wr(5, 16'h2000, "R8");
        conv(0, 1'b1, "R8"); conv(1000, 1'b1, "R8"); conv(3000, 1'b1, "R8");
        drain("R2");
        // R9: write on the same edge as a conversion uses the old value
        wr(5, 16'h0000, "R9");
        cyc(1'b1, 1500, 1'b1, 1'b1, 5, 16'h0100, "R9");
        cyc(1'b1, 1500, 1'b1, 1'b1, 4, 16'h2000, "R9");
        cyc(1'b0, 0, 1'b0, 1'b1, 5, 16'h3F00, "R9");
        cyc(1'b1, 1500, 1'b1, 1'b0, 0, 0, "R9");
        drain("R9");
        // R2: back-to-back burst with mixed modes
        for (int i = 0; i < 10; i++)
            conv((i * 409 + 17) % 4096, bit'(i % 3 != 0), "R2");
        drain("R2");
        // R3: sweep of corrected values under a mid gain and positive offset
        wr(4, 16'h4321, "R3"); wr(5, 16'h0035, "R3");
        for (int i = 0; i < 8; i++) conv(i * 511, 1'b1, "R3");
        drain("R3");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2: watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule